// File: doc/BRIEF.md
# Line-Lockable Two-Way Cache Tag Controller

This block holds the tag state for a pair of equally sized two-way set-associative caches, one for instructions and one for data. It answers lookups with hit, hit way and a proposed victim way. It records fills, invalidations and per-line unlocks. It keeps no data: per set and per cache it stores a valid bit and a tag for each way, one lock bit for way A and one LRU bit. Data arrays and the refill engine sit outside it.

Any line in way A can be pinned individually. Each cache has its own lock-enable input. While that input is high, every fill into way A of that cache sets the lock bit of the filled line. A locked line is never proposed as a victim, and it cannot be overwritten by a fill.

Dropping a lock-enable only stops new lines from being locked. Lines that are already pinned stay pinned until an unlock command for their set, or an invalidate of way A, releases them.

Top module: `lkc_cache_ctrl`

## Requirements
- R1: After reset every line of both caches is invalid and unlocked, and every LRU bit points at way A. A lookup then misses, reports locked=0 and proposes victim way A.
- R2: Opcodes: 0 is lookup, 1 is fill, 2 is unlock, 3 is invalidate. A lookup accepted on one rising edge drives rsp_valid high with its result after that edge, for one cycle. Any other opcode, or no request, leaves rsp_valid low after the edge.
- R3: A lookup hits when a valid way of the selected set holds the request tag, and rsp_way reports that way (0 = way A, 1 = way B). A hit sets the set's LRU bit to point at the way that was not hit.
- R4: When the way A line is not locked, the victim is chosen in this order: an invalid way A first, then an invalid way B, otherwise the way named by the LRU bit.
- R5: When the way A line of the set is locked, the victim is way B, and rsp_locked is 1.
- R6: A fill into way A sets that line's lock bit to the value of its cache's lock-enable. Cache select 0 uses lock_en_i and select 1 uses lock_en_d, and neither input affects the other cache.
- R7: Deasserting a lock-enable leaves every lock bit that is already set unchanged.
- R8: An unlock command clears the way A lock bit of the addressed set and changes nothing else.
- R9: A fill into way A of a set whose way A line is locked is ignored. Tag, valid, lock and LRU bits all stay as they were.
- R10: Invalidating way A clears both its valid bit and its lock bit. Invalidating way B clears only way B's valid bit.
- R11: An accepted fill into way A sets the LRU bit to way B. A fill into way B sets it to way A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request strobe |
| req_sel | input | 1 | Cache select: 0 instruction, 1 data |
| req_op | input | 2 | Opcode: 0 lookup, 1 fill, 2 unlock, 3 invalidate |
| req_index | input | INDEX_W | Set index |
| req_tag | input | TAG_W | Tag for lookup or fill |
| req_way | input | 1 | Target way for fill or invalidate (0 = A, 1 = B) |
| lock_en_i | input | 1 | Lock-enable for instruction cache fills into way A |
| lock_en_d | input | 1 | Lock-enable for data cache fills into way A |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Lookup hit |
| rsp_way | output | 1 | Hit way |
| rsp_victim | output | 1 | Proposed victim way for a miss |
| rsp_locked | output | 1 | Way A lock bit of the looked-up set |

## Verification
Some properties are checked on every cycle by assertions:
- The response timing.
- A locked set always proposes way B.
- A lock bit only rises through a way A fill with its enable high.
- An unlock always clears its bit.
- A locked way A tag is never written.

Other behaviour only shows up in the bench's scenarios, which compare every lookup against a reference model:
- The victim priority among invalid ways and LRU.
- The LRU updates after hits and fills.
- The separation of the two lock-enables.
- The survival of pinned lines across repeated misses after the enable is dropped.

// File: rtl/lkc_pkg.sv
package lkc_pkg;
  typedef enum logic [1:0] {
    OP_LOOKUP = 2'd0,
    OP_FILL   = 2'd1,
    OP_UNLOCK = 2'd2,
    OP_INVAL  = 2'd3
  } lkc_op_e;

  localparam logic WAY_A = 1'b0;
  localparam logic WAY_B = 1'b1;
  localparam int   NCACHE = 2;
endpackage

// File: rtl/lkc_set_store.sv
module lkc_set_store
  import lkc_pkg::*;
#(
  parameter int INDEX_W = 5,
  parameter int TAG_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [INDEX_W-1:0] idx,
  input  logic [TAG_W-1:0]   tag,
  input  logic               way,
  input  logic               op_fill,
  input  logic               op_unlock,
  input  logic               op_inval,
  input  logic               op_hit,
  input  logic               hit_way,
  input  logic               lock_set_en,
  output logic               ent_valid_a,
  output logic               ent_valid_b,
  output logic [TAG_W-1:0]   ent_tag_a,
  output logic [TAG_W-1:0]   ent_tag_b,
  output logic               ent_lock,
  output logic               ent_lru
);
  localparam int SETS = 1 << INDEX_W;

  logic [SETS-1:0]  valid_a_q, valid_a_d;
  logic [SETS-1:0]  valid_b_q, valid_b_d;
  logic [SETS-1:0]  lock_q, lock_d;
  logic [SETS-1:0]  lru_q, lru_d;
  logic [TAG_W-1:0] tag_a_q [SETS];
  logic [TAG_W-1:0] tag_b_q [SETS];
  logic             state_en;
  logic             fill_a_ok;
  logic             tag_we_a;
  logic             tag_we_b;

  // Way A fills are refused while the line is pinned.
  assign fill_a_ok = op_fill && (way == WAY_A) && !lock_q[idx];
  assign tag_we_a  = fill_a_ok;
  assign tag_we_b  = op_fill && (way == WAY_B);
  assign state_en  = op_fill || op_unlock || op_inval || op_hit;

  always_comb begin
    valid_a_d = valid_a_q;
    valid_b_d = valid_b_q;
    lock_d    = lock_q;
    lru_d     = lru_q;
    if (fill_a_ok) begin
      valid_a_d[idx] = 1'b1;
      lock_d[idx]    = lock_set_en;
      lru_d[idx]     = WAY_B;
    end
    if (tag_we_b) begin
      valid_b_d[idx] = 1'b1;
      lru_d[idx]     = WAY_A;
    end
    if (op_unlock) begin
      lock_d[idx] = 1'b0;
    end
    if (op_inval) begin
      if (way == WAY_A) begin
        valid_a_d[idx] = 1'b0;
        lock_d[idx]    = 1'b0;
      end else begin
        valid_b_d[idx] = 1'b0;
      end
    end
    if (op_hit) begin
      lru_d[idx] = ~hit_way;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_a_q <= '0;
      valid_b_q <= '0;
      lock_q    <= '0;
      lru_q     <= '0;
    end else if (state_en) begin
      valid_a_q <= valid_a_d;
      valid_b_q <= valid_b_d;
      lock_q    <= lock_d;
      lru_q     <= lru_d;
    end
  end

  // Tag storage carries no reset; valid bits qualify it.
  always_ff @(posedge clk) begin
    if (tag_we_a) tag_a_q[idx] <= tag;
    if (tag_we_b) tag_b_q[idx] <= tag;
  end

  assign ent_valid_a = valid_a_q[idx];
  assign ent_valid_b = valid_b_q[idx];
  assign ent_tag_a   = tag_a_q[idx];
  assign ent_tag_b   = tag_b_q[idx];
  assign ent_lock    = lock_q[idx];
  assign ent_lru     = lru_q[idx];

  assert_locked_tag_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(tag_we_a && lock_q[idx]));

  assert_lock_rise_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((lock_d & ~lock_q) != '0) |-> (op_fill && (way == WAY_A) && lock_set_en));

  assert_unlock_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_unlock |-> !lock_d[idx]);

  assert_one_lock_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(lock_d ^ lock_q) <= 1);
endmodule

// File: rtl/lkc_way_match.sv
module lkc_way_match
  import lkc_pkg::*;
#(
  parameter int TAG_W = 20
) (
  input  logic             valid_a,
  input  logic             valid_b,
  input  logic [TAG_W-1:0] tag_a,
  input  logic [TAG_W-1:0] tag_b,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             lock_a,
  input  logic             lru,
  output logic             hit,
  output logic             hit_way,
  output logic             victim
);
  logic hit_a;
  logic hit_b;

  assign hit_a   = valid_a && (tag_a == req_tag);
  assign hit_b   = valid_b && (tag_b == req_tag);
  assign hit     = hit_a || hit_b;
  assign hit_way = hit_a ? WAY_A : WAY_B;

  always_comb begin
    if (lock_a)        victim = WAY_B;
    else if (!valid_a) victim = WAY_A;
    else if (!valid_b) victim = WAY_B;
    else               victim = lru;
  end
endmodule

// File: rtl/lkc_resp_reg.sv
module lkc_resp_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic hit,
  input  logic hit_way,
  input  logic victim,
  input  logic locked,
  output logic rsp_valid,
  output logic rsp_hit,
  output logic rsp_way,
  output logic rsp_victim,
  output logic rsp_locked
);
  logic hit_d;

  assign hit_d = load && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= load;
      rsp_hit   <= hit_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_way    <= 1'b0;
      rsp_victim <= 1'b0;
      rsp_locked <= 1'b0;
    end else if (load) begin
      rsp_way    <= hit_way;
      rsp_victim <= victim;
      rsp_locked <= locked;
    end
  end
endmodule

// File: rtl/lkc_cache_ctrl.sv
module lkc_cache_ctrl
  import lkc_pkg::*;
#(
  parameter int INDEX_W = 5,
  parameter int TAG_W   = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic               req_sel,
  input  logic [1:0]         req_op,
  input  logic [INDEX_W-1:0] req_index,
  input  logic [TAG_W-1:0]   req_tag,
  input  logic               req_way,
  input  logic               lock_en_i,
  input  logic               lock_en_d,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic               rsp_way,
  output logic               rsp_victim,
  output logic               rsp_locked
);
  logic [NCACHE-1:0] lock_en_vec;
  logic              ent_valid_a [NCACHE];
  logic              ent_valid_b [NCACHE];
  logic [TAG_W-1:0]  ent_tag_a   [NCACHE];
  logic [TAG_W-1:0]  ent_tag_b   [NCACHE];
  logic              ent_lock    [NCACHE];
  logic              ent_lru     [NCACHE];
  logic              is_lookup;
  logic              m_hit;
  logic              m_way;
  logic              m_victim;

  assign lock_en_vec = {lock_en_d, lock_en_i};
  assign is_lookup   = req_valid && (req_op == OP_LOOKUP);

  for (genvar g = 0; g < NCACHE; g++) begin : g_cache
    logic mine;
    assign mine = req_valid && (req_sel == 1'(g));

    lkc_set_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .idx         (req_index),
      .tag         (req_tag),
      .way         (req_way),
      .op_fill     (mine && (req_op == OP_FILL)),
      .op_unlock   (mine && (req_op == OP_UNLOCK)),
      .op_inval    (mine && (req_op == OP_INVAL)),
      .op_hit      (mine && (req_op == OP_LOOKUP) && m_hit),
      .hit_way     (m_way),
      .lock_set_en (lock_en_vec[g]),
      .ent_valid_a (ent_valid_a[g]),
      .ent_valid_b (ent_valid_b[g]),
      .ent_tag_a   (ent_tag_a[g]),
      .ent_tag_b   (ent_tag_b[g]),
      .ent_lock    (ent_lock[g]),
      .ent_lru     (ent_lru[g])
    );
  end

  lkc_way_match #(.TAG_W(TAG_W)) u_match (
    .valid_a (ent_valid_a[req_sel]),
    .valid_b (ent_valid_b[req_sel]),
    .tag_a   (ent_tag_a[req_sel]),
    .tag_b   (ent_tag_b[req_sel]),
    .req_tag (req_tag),
    .lock_a  (ent_lock[req_sel]),
    .lru     (ent_lru[req_sel]),
    .hit     (m_hit),
    .hit_way (m_way),
    .victim  (m_victim)
  );

  lkc_resp_reg u_resp (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (is_lookup),
    .hit        (m_hit),
    .hit_way    (m_way),
    .victim     (m_victim),
    .locked     (ent_lock[req_sel]),
    .rsp_valid  (rsp_valid),
    .rsp_hit    (rsp_hit),
    .rsp_way    (rsp_way),
    .rsp_victim (rsp_victim),
    .rsp_locked (rsp_locked)
  );

  assert_resp_follows_lookup_R2: assert property (@(posedge clk) disable iff (!rst_n)
    is_lookup |=> rsp_valid);

  assert_no_resp_otherwise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !is_lookup |=> !rsp_valid);

  assert_locked_victim_is_b_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_locked) |-> (rsp_victim == WAY_B));

  assert_hit_only_with_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !rsp_hit);
endmodule

// File: tb/lkc_cache_ctrl_bench.sv
`timescale 1ns/1ps
module lkc_cache_ctrl_bench;
  localparam int INDEX_W = 5;
  localparam int TAG_W   = 20;
  localparam int SETS    = 1 << INDEX_W;

  logic               clk;
  logic               rst_n;
  logic               req_valid;
  logic               req_sel;
  logic [1:0]         req_op;
  logic [INDEX_W-1:0] req_index;
  logic [TAG_W-1:0]   req_tag;
  logic               req_way;
  logic               lock_en_i;
  logic               lock_en_d;
  logic               rsp_valid, rsp_hit, rsp_way, rsp_victim, rsp_locked;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic             m_va  [2][SETS];
  logic             m_vb  [2][SETS];
  logic [TAG_W-1:0] m_ta  [2][SETS];
  logic [TAG_W-1:0] m_tb  [2][SETS];
  logic             m_lk  [2][SETS];
  logic             m_lru [2][SETS];

  lkc_cache_ctrl #(.INDEX_W(INDEX_W), .TAG_W(TAG_W)) u_lkc_cache_ctrl (
    .clk, .rst_n, .req_valid, .req_sel, .req_op, .req_index, .req_tag, .req_way,
    .lock_en_i, .lock_en_d, .rsp_valid, .rsp_hit, .rsp_way, .rsp_victim, .rsp_locked
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic exp_hit(int s, int i, logic [TAG_W-1:0] t);
    return (m_va[s][i] && m_ta[s][i] == t) || (m_vb[s][i] && m_tb[s][i] == t);
  endfunction

  function automatic logic exp_way(int s, int i, logic [TAG_W-1:0] t);
    return (m_va[s][i] && m_ta[s][i] == t) ? 1'b0 : 1'b1;
  endfunction

  function automatic logic exp_victim(int s, int i);
    if (m_lk[s][i])       return 1'b1;
    else if (!m_va[s][i]) return 1'b0;
    else if (!m_vb[s][i]) return 1'b1;
    else                  return m_lru[s][i];
  endfunction

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", rq, what, act, exp);
    end
  endtask

  task automatic do_op(input int s, input logic [1:0] op, input int i,
                       input logic [TAG_W-1:0] t, input logic w, input string rq);
    logic eh, ew, ev, el, lk_en;
    eh = exp_hit(s, i, t);
    ew = exp_way(s, i, t);
    ev = exp_victim(s, i);
    el = m_lk[s][i];
    lk_en = (s == 0) ? lock_en_i : lock_en_d;
    req_valid = 1'b1;
    req_sel   = 1'(s);
    req_op    = op;
    req_index = INDEX_W'(i);
    req_tag   = t;
    req_way   = w;
    @(negedge clk);
    req_valid = 1'b0;
    if (op == 2'd0) begin
      check(rsp_valid && rsp_hit == eh && (!eh || rsp_way == ew) &&
            rsp_victim == ev && rsp_locked == el, rq, "lookup {hit,way,victim,locked}",
            {rsp_hit, rsp_way, rsp_victim, rsp_locked}, {eh, eh ? ew : rsp_way, ev, el});
      if (eh) m_lru[s][i] = ~ew;
    end else begin
      check(!rsp_valid, "R2", "rsp_valid after non-lookup", {3'b0, rsp_valid}, 4'b0);
      case (op)
        2'd1: if (w == 1'b0) begin
                if (!m_lk[s][i]) begin
                  m_va[s][i] = 1'b1; m_ta[s][i] = t; m_lk[s][i] = lk_en; m_lru[s][i] = 1'b1;
                end
              end else begin
                m_vb[s][i] = 1'b1; m_tb[s][i] = t; m_lru[s][i] = 1'b0;
              end
        2'd2: m_lk[s][i] = 1'b0;
        default: if (w == 1'b0) begin
                   m_va[s][i] = 1'b0; m_lk[s][i] = 1'b0;
                 end else m_vb[s][i] = 1'b0;
      endcase
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4077));
    for (int s = 0; s < 2; s++)
      for (int i = 0; i < SETS; i++) begin
        m_va[s][i] = 0; m_vb[s][i] = 0; m_ta[s][i] = '0; m_tb[s][i] = '0;
        m_lk[s][i] = 0; m_lru[s][i] = 0;
      end
    rst_n = 1'b0; req_valid = 1'b0; req_sel = 1'b0; req_op = 2'd0;
    req_index = '0; req_tag = '0; req_way = 1'b0; lock_en_i = 1'b0; lock_en_d = 1'b0;
    repeat (3) @(negedge clk);
    check(!rsp_valid && !rsp_hit, "R1", "outputs in reset", {2'b0, rsp_valid, rsp_hit}, 4'b0);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: empty caches miss with victim A
    do_op(0, 2'd0, 0, 20'h00001, 1'b0, "R1");
    do_op(1, 2'd0, 31, 20'h00002, 1'b0, "R1");
    // R4 / R11 / R3 victim ordering and LRU
    do_op(0, 2'd1, 2, 20'h00aa, 1'b0, "R11");
    do_op(0, 2'd0, 2, 20'h00bb, 1'b0, "R4");
    do_op(0, 2'd1, 2, 20'h00bb, 1'b1, "R11");
    do_op(0, 2'd0, 2, 20'h00cc, 1'b0, "R4");
    do_op(0, 2'd0, 2, 20'h00bb, 1'b0, "R3");
    do_op(0, 2'd0, 2, 20'h00cc, 1'b0, "R3");
    // R6 / R7 / R5 / R9: pin a data line, drop enable, hammer the set
    lock_en_i = 1'b1; lock_en_d = 1'b0;
    do_op(1, 2'd1, 3, 20'h0333, 1'b0, "R6");
    do_op(1, 2'd0, 3, 20'h0999, 1'b0, "R6");
    lock_en_i = 1'b0; lock_en_d = 1'b1;
    do_op(1, 2'd1, 7, 20'h0111, 1'b0, "R6");
    lock_en_d = 1'b0;
    for (int k = 0; k < 6; k++) begin
      do_op(1, 2'd0, 7, 20'h0200 + TAG_W'(k), 1'b0, "R5");
      do_op(1, 2'd1, 7, 20'h0200 + TAG_W'(k), 1'b1, "R7");
      do_op(1, 2'd1, 7, 20'h0300 + TAG_W'(k), 1'b0, "R9");
    end
    do_op(1, 2'd0, 7, 20'h0111, 1'b0, "R7");
    // R8 unlock, then way A is replaceable again
    do_op(1, 2'd2, 7, 20'h0, 1'b0, "R8");
    do_op(1, 2'd0, 7, 20'h0205, 1'b0, "R8");
    do_op(1, 2'd0, 7, 20'h0777, 1'b0, "R8");
    // R10 invalidate of a locked way A
    lock_en_d = 1'b1;
    do_op(1, 2'd1, 9, 20'h0444, 1'b0, "R10");
    lock_en_d = 1'b0;
    do_op(1, 2'd3, 9, 20'h0, 1'b0, "R10");
    do_op(1, 2'd0, 9, 20'h0444, 1'b0, "R10");
    // Random mix across both caches, few sets and tags to force conflicts
    for (int n = 0; n < 4000; n++) begin
      int s, i, r;
      logic [1:0] op;
      s = int'($urandom_range(0, 1));
      i = int'($urandom_range(0, 3));
      r = int'($urandom_range(0, 99));
      op = (r < 50) ? 2'd0 : (r < 85) ? 2'd1 : (r < 93) ? 2'd2 : 2'd3;
      if ($urandom_range(0, 15) == 0) lock_en_i = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 15) == 0) lock_en_d = 1'($urandom_range(0, 1));
      do_op(s, op, i, TAG_W'($urandom_range(0, 5)), 1'($urandom_range(0, 1)), "R4");
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule